// File: doc/BRIEF.md
# Ancillary Packet Checksum Checker and Inserter

This block sits in a 10-bit parallel video data path and handles the checksum of each ancillary data packet in the stream. It finds the start of a packet by the three-word flag sequence 000h, 3FFh, 3FFh. It then follows the header and the user data words and adds up their low nine bits. From the data count it knows which word is the checksum slot.

Two control bits select what happens at that slot. When the stream is said to carry its own checksums, the block compares the received word with its own result. A wrong checksum is either replaced in the output, or left in place and reported through a sticky error flag. When the stream carries no checksums, the slot holds a placeholder, and the block always writes its own checksum into it. Every word, inside a packet or not, leaves the block exactly one valid cycle after it arrives. Cycles with the valid strobe low do not advance the packet tracking.

Top module: `anc_cs_engine`

## Requirements
- R1: A packet starts after three consecutive valid words 000h, 3FFh, 3FFh. The next three valid words are the DID, the SDID/DBN and the data count. A broken flag sequence starts no packet.
- R2: The computed checksum is the 9-bit modulo sum of bits 8:0 of the DID, the SDID/DBN, the data count and every user data word. Its bit 9 is the inverse of its bit 8.
- R3: Bits 7:0 of the data count word give the number of user data words, from 0 to 255. Bits 9:8 of that word are ignored. The checksum slot is the valid word right after the last user data word, or right after the data count when the count is zero.
- R4: With attach_in=1 and a received checksum equal to the computed word, the word passes out unchanged and no error is reported.
- R5: With attach_in=1, force_cs=1 and a mismatch, the computed checksum replaces the received word in the output. cs_err_pulse is high for one cycle and cs_err is not set.
- R6: With attach_in=1, force_cs=0 and a mismatch, the received word passes out unchanged, cs_err_pulse is high for one cycle and cs_err is set.
- R7: With attach_in=0, the checksum slot is always replaced by the computed checksum, whatever the placeholder holds. Neither error output is raised and force_cs has no effect.
- R8: cs_err stays set until err_clr is sampled high. A mismatch that sets the flag in the same cycle as err_clr wins, and the flag stays set.
- R9: dout and dout_vld follow din and din_vld by exactly one clock cycle. Every word that is not a checksum slot leaves unchanged. Cycles with din_vld low do not advance packet tracking.
- R10: While reset is active, dout, dout_vld, cs_err and cs_err_pulse are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 10 | Input data word |
| din_vld | input | 1 | Input word strobe |
| attach_in | input | 1 | 1: stream carries checksums; 0: fill slot with computed checksum |
| force_cs | input | 1 | Replace a mismatching received checksum |
| err_clr | input | 1 | Clears the sticky error flag |
| dout | output | 10 | Output data word, one cycle delayed |
| dout_vld | output | 1 | Output word strobe |
| cs_err | output | 1 | Sticky checksum mismatch flag |
| cs_err_pulse | output | 1 | One-cycle pulse per mismatch |

## Verification
The bench builds the block with its default widths: 10-bit words and an 8-bit data count. This makes the whole range of packet lengths reachable. Counts 0 through 20 are swept under all eight combinations of attach, force and corrupted checksum, and a 255-word packet is added. Strobe gaps inside packets, broken and restarted flag sequences, and a clear that lands in the same cycle as a mismatch are driven explicitly. The expected checksum is summed in the bench from the words it sends.

// File: rtl/anc_cs_pkg.sv
package anc_cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DID,
        ST_SDID,
        ST_DC,
        ST_UDW,
        ST_CS
    } trk_state_e;

endpackage

// File: rtl/anc_flag_detect.sv
module anc_flag_detect #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] word,
    input  logic              vld,
    output logic              hit
);
    localparam logic [DATA_W-1:0] FLAG_LO = '0;
    localparam logic [DATA_W-1:0] FLAG_HI = '1;

    // progress through the three-word flag: 0 none, 1 low seen, 2 low+high seen
    typedef struct packed {
        logic [1:0] prog;
    } det_t;

    det_t d_d, d_q;

    assign hit = vld && (d_q.prog == 2'd2) && (word == FLAG_HI);

    always_comb begin
        d_d = d_q;
        if (vld) begin
            if (word == FLAG_LO) begin
                d_d.prog = 2'd1;
            end else if (hit) begin
                d_d.prog = 2'd0;
            end else if ((d_q.prog == 2'd1) && (word == FLAG_HI)) begin
                d_d.prog = 2'd2;
            end else begin
                d_d.prog = 2'd0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    // R1
    property flag_prefix_p;
        @(posedge clk) disable iff (!rst_n)
            hit |-> ($past(d_q.prog) == 2'd1 || $past(d_q.prog) == 2'd2);
    endproperty
    flag_prefix_chk: assert property (flag_prefix_p);

endmodule

// File: rtl/anc_pkt_tracker.sv
module anc_pkt_tracker
    import anc_cs_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] word,
    input  logic              vld,
    input  logic              flag_hit,
    output logic              is_cs,
    output logic [DATA_W-1:0] calc_cs
);
    localparam int SUM_W = DATA_W - 1;

    typedef struct packed {
        trk_state_e       state;
        logic [SUM_W-1:0] sum;
        logic [CNT_W-1:0] cnt;
    } trk_t;

    trk_t t_d, t_q;
    logic [CNT_W-1:0] dc_val;

    assign dc_val  = word[CNT_W-1:0];
    assign is_cs   = (t_q.state == ST_CS);
    assign calc_cs = {~t_q.sum[SUM_W-1], t_q.sum};

    always_comb begin
        t_d = t_q;
        if (vld) begin
            unique case (t_q.state)
                ST_IDLE: begin
                    if (flag_hit) begin
                        t_d.state = ST_DID;
                    end
                end
                ST_DID: begin
                    t_d.sum   = word[SUM_W-1:0];
                    t_d.state = ST_SDID;
                end
                ST_SDID: begin
                    t_d.sum   = t_q.sum + word[SUM_W-1:0];
                    t_d.state = ST_DC;
                end
                ST_DC: begin
                    t_d.sum   = t_q.sum + word[SUM_W-1:0];
                    t_d.cnt   = dc_val;
                    t_d.state = (dc_val == '0) ? ST_CS : ST_UDW;
                end
                ST_UDW: begin
                    t_d.sum = t_q.sum + word[SUM_W-1:0];
                    t_d.cnt = t_q.cnt - 1'b1;
                    if (t_q.cnt == CNT_W'(1)) begin
                        t_d.state = ST_CS;
                    end
                end
                ST_CS: begin
                    t_d.state = ST_IDLE;
                end
                default: begin
                    t_d.state = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '{state: ST_IDLE, sum: '0, cnt: '0};
        end else begin
            t_q <= t_d;
        end
    end

    // R3
    property udw_count_live_p;
        @(posedge clk) disable iff (!rst_n)
            (t_q.state == ST_UDW) |-> (t_q.cnt != '0);
    endproperty
    udw_count_live_chk: assert property (udw_count_live_p);

    // R1
    property packet_start_p;
        @(posedge clk) disable iff (!rst_n)
            (vld && flag_hit && t_q.state == ST_IDLE) |=> (t_q.state == ST_DID);
    endproperty
    packet_start_chk: assert property (packet_start_p);

    // R9
    property hold_when_idle_strobe_p;
        @(posedge clk) disable iff (!rst_n)
            !vld |=> $stable(t_q.state);
    endproperty
    hold_when_idle_strobe_chk: assert property (hold_when_idle_strobe_p);

endmodule

// File: rtl/anc_cs_engine.sv
module anc_cs_engine #(
    parameter int DATA_W = 10,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              din_vld,
    input  logic              attach_in,
    input  logic              force_cs,
    input  logic              err_clr,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld,
    output logic              cs_err,
    output logic              cs_err_pulse
);
    typedef struct packed {
        logic [DATA_W-1:0] dout;
        logic              vld;
        logic              pulse;
        logic              flag;
    } eng_t;

    eng_t e_d, e_q;

    logic              flag_hit;
    logic              is_cs;
    logic [DATA_W-1:0] calc_cs;
    logic              mismatch;
    logic              set_flag;

    anc_flag_detect #(
        .DATA_W(DATA_W)
    ) u_detect (
        .clk  (clk),
        .rst_n(rst_n),
        .word (din),
        .vld  (din_vld),
        .hit  (flag_hit)
    );

    anc_pkt_tracker #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .word    (din),
        .vld     (din_vld),
        .flag_hit(flag_hit),
        .is_cs   (is_cs),
        .calc_cs (calc_cs)
    );

    assign mismatch = din_vld && is_cs && attach_in && (din != calc_cs);
    assign set_flag = mismatch && !force_cs;

    always_comb begin
        e_d       = e_q;
        e_d.vld   = din_vld;
        e_d.pulse = mismatch;
        if (din_vld) begin
            e_d.dout = din;
            if (is_cs && (!attach_in || (mismatch && force_cs))) begin
                e_d.dout = calc_cs;
            end
        end
        if (set_flag) begin
            e_d.flag = 1'b1;
        end else if (err_clr) begin
            e_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign dout         = e_q.dout;
    assign dout_vld     = e_q.vld;
    assign cs_err       = e_q.flag;
    assign cs_err_pulse = e_q.pulse;

    // R9
    property latency_p;
        @(posedge clk) disable iff (!rst_n)
            dout_vld == $past(din_vld);
    endproperty
    latency_chk: assert property (latency_p);

    // R9
    property passthru_p;
        @(posedge clk) disable iff (!rst_n)
            (dout_vld && !$past(is_cs)) |-> (dout == $past(din));
    endproperty
    passthru_chk: assert property (passthru_p);

    // R7
    property insert_no_err_p;
        @(posedge clk) disable iff (!rst_n)
            cs_err_pulse |-> $past(attach_in);
    endproperty
    insert_no_err_chk: assert property (insert_no_err_p);

    // R8
    property sticky_hold_p;
        @(posedge clk) disable iff (!rst_n)
            ($past(cs_err) && !$past(err_clr)) |-> cs_err;
    endproperty
    sticky_hold_chk: assert property (sticky_hold_p);

    // R2
    property cs_format_p;
        @(posedge clk) disable iff (!rst_n)
            (dout_vld && dout != $past(din)) |-> (dout[DATA_W-1] != dout[DATA_W-2]);
    endproperty
    cs_format_chk: assert property (cs_format_p);

endmodule

// File: tb/tb_anc_cs_engine.sv
module tb_anc_cs_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] din = '0;
    logic       din_vld = 1'b0;
    logic       attach_in = 1'b0;
    logic       force_cs = 1'b0;
    logic       err_clr = 1'b0;
    logic [9:0] dout;
    logic       dout_vld;
    logic       cs_err;
    logic       cs_err_pulse;

    int n_vec = 0;
    int n_bad = 0;
    logic exp_flag = 1'b0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    anc_cs_engine dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .din         (din),
        .din_vld     (din_vld),
        .attach_in   (attach_in),
        .force_cs    (force_cs),
        .err_clr     (err_clr),
        .dout        (dout),
        .dout_vld    (dout_vld),
        .cs_err      (cs_err),
        .cs_err_pulse(cs_err_pulse)
    );

    // one word per cycle; drive at a falling edge, check at the next falling edge
    task automatic step(input logic [9:0] w, input logic v, input logic [9:0] ew,
                        input logic ep, input logic eset, input logic clr,
                        input string req);
        din     = w;
        din_vld = v;
        err_clr = clr;
        @(negedge clk);
        if (eset) exp_flag = 1'b1;
        else if (clr) exp_flag = 1'b0;
        n_vec++;
        if (dout_vld !== v || (v && dout !== ew) || cs_err_pulse !== ep
            || cs_err !== exp_flag) begin
            n_bad++;
            $display("FAIL %s: dout=%h vld=%b pulse=%b err=%b exp dout=%h vld=%b pulse=%b err=%b",
                     req, dout, dout_vld, cs_err_pulse, cs_err, ew, v, ep, exp_flag);
        end
        err_clr = 1'b0;
    endtask

    task automatic pass(input logic [9:0] w, input string req);
        step(w, 1'b1, w, 1'b0, 1'b0, 1'b0, req);
    endtask

    // R1 R2 R3 R4 R5 R6 R7: one packet, checksum summed here from the words sent
    task automatic send_pkt(input int dc, input logic att, input logic frc,
                            input logic bad, input logic gap, input logic clr_at_cs);
        logic [8:0] s;
        logic [9:0] good, rx, ew;
        logic [7:0] dc8;
        logic       mis;
        attach_in = att;
        force_cs  = frc;
        dc8 = 8'(dc);
        pass(10'h000, "R1");
        pass(10'h3FF, "R1");
        pass(10'h3FF, "R1");
        pass(10'h1A3, "R1");
        s = 9'h1A3;
        pass(10'h2C5, "R1");
        s = s + 9'h0C5;
        // bits 9:8 of the count word carry parity and must not matter (R3)
        pass({~(^dc8), ^dc8, dc8}, "R3");
        s = s + {^dc8, dc8};
        if (gap) step(10'h2AA, 1'b0, 10'h0, 1'b0, 1'b0, 1'b0, "R9");
        for (int i = 0; i < dc; i++) begin
            logic [9:0] u;
            u = 10'((dc * 37 + i * 113 + 5) & 10'h3FF);
            pass(u, "R2");
            s = s + u[8:0];
        end
        if (gap) step(10'h155, 1'b0, 10'h0, 1'b0, 1'b0, 1'b0, "R9");
        good = {~s[8], s};
        if (!att) rx = bad ? 10'h155 : 10'h000;
        else rx = bad ? (good ^ 10'h004) : good;
        mis = att && bad;
        ew  = (!att || (mis && frc)) ? good : rx;
        step(rx, 1'b1, ew, mis, mis && !frc, clr_at_cs,
             !att ? "R7" : (!mis ? "R4" : (frc ? "R5" : "R6")));
        pass(10'h040, "R9");
    endtask

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        n_vec++;
        if (dout !== 10'h0 || dout_vld !== 1'b0 || cs_err !== 1'b0 || cs_err_pulse !== 1'b0) begin
            n_bad++;
            $display("FAIL R10: dout=%h vld=%b err=%b pulse=%b exp all zero",
                     dout, dout_vld, cs_err, cs_err_pulse);
        end
        rst_n = 1'b1;

        // R9 plain words and gaps
        pass(10'h123, "R9");
        step(10'h321, 1'b0, 10'h0, 1'b0, 1'b0, 1'b0, "R9");
        pass(10'h3FF, "R9");
        // R1 broken flag sequences: next words must pass unchanged
        attach_in = 1'b0;
        pass(10'h000, "R1");
        pass(10'h3FF, "R1");
        pass(10'h155, "R1");
        pass(10'h000, "R1");
        pass(10'h155, "R1");
        pass(10'h3FF, "R1");
        pass(10'h3FF, "R1");
        for (int k = 0; k < 8; k++) pass(10'(k * 77 + 3), "R1");

        // sweep counts and all control combinations
        for (int dc = 0; dc <= 20; dc++) begin
            for (int m = 0; m < 8; m++) begin
                send_pkt(dc, m[2], m[1], m[0], (dc % 3) == 0, 1'b0);
                if (exp_flag) begin
                    attach_in = 1'b1;
                    step(10'h011, 1'b1, 10'h011, 1'b0, 1'b0, 1'b1, "R8");
                end
            end
        end

        // R3 longest packet
        send_pkt(255, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        send_pkt(255, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);

        // R8 sticky across packets, set wins against simultaneous clear
        send_pkt(4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        send_pkt(2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        pass(10'h0AA, "R8");
        send_pkt(3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        step(10'h0BB, 1'b1, 10'h0BB, 1'b0, 1'b0, 1'b1, "R8");
        // R1 restart: second low word restarts the flag
        attach_in = 1'b1;
        force_cs  = 1'b0;
        pass(10'h000, "R1");
        send_pkt(1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule